// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers 32 peripheral interrupt lines and decides which of them the processor should service next. Software programs it through a small register port. Two write-one register pairs turn the enable bit and the pending bit of each line on and off. Eight priority words each hold four 8-bit urgency fields. Each line keeps three separate bits: enabled, pending and active. A line that is pending, enabled and not active is a candidate. The most urgent candidate is presented to the processor as a request, together with its vector number and the byte address of its handler entry in a vector table that starts at address 0.

When the processor accepts the request, that line moves from pending to active. An exception-return strobe, which carries the line number, clears the active bit again. A new request is raised only when nothing is active, or when the best candidate is strictly more urgent than the most urgent active line. This allows a more urgent line to preempt a less urgent one. Interrupt lines are treated as levels.

Top module: `irq_ctrl_core`

## Requirements
- R1: After reset, the enable, pending, active and priority state is all zero. `irq_req` is low, and every register reads 0.
- R2: A write to address 0x00 enables each line whose data bit is 1. A write to 0x04 disables each line whose data bit is 1. Data bits that are 0 change nothing. Reading either address returns the 32 enable bits, with bit n for line n.
- R3: A write to 0x08 sets the pending bit of each line whose data bit is 1. A write to 0x0C clears it. Data bits that are 0 change nothing. Reading either address returns the 32 pending bits.
- R4: A line that goes high while disabled becomes pending and stays pending after it drops. It raises no request until it is enabled.
- R5: The urgency of line n is byte lane n%4 (bits 8*(n%4)+7 down to 8*(n%4)) of the priority word at address 0x20+4*(n/4). These words read back as written.
- R6: Among the candidates, the lowest urgency value wins. On equal values, the lower line number wins.
- R7: The vector number presented is n+16 for line n. The handler address is 4*(n+16), so line 26 gives 42 and 0xA8.
- R8: An acknowledge while `irq_req` is high moves the chosen line from pending to active at that clock edge. An active line is not a candidate.
- R9: `irq_req` is high only when a candidate exists and either no line is active or the candidate's value is strictly lower than that of the most urgent active line.
- R10: An exception-return strobe clears the active bit of the line named on `exc_ret_id` at that clock edge.
- R11: Disabling a line or clearing its pending bit while it is active leaves it active, and its pending bit is also unaffected by the clear.
- R12: A high line sets its pending bit on every edge while it is not active. This overrides a clear-pending write in the same cycle. A high line does not set pending while the line is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 32 | Level interrupt inputs, one per line |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe, acted on at the clock edge |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_req | output | 1 | Request to the processor |
| irq_vec_num | output | 6 | Vector number of the chosen line |
| irq_vec_addr | output | 32 | Handler entry byte address |
| irq_ack | input | 1 | Processor accepts the current request |
| exc_ret | input | 1 | Exception return strobe |
| exc_ret_id | input | 5 | Line number being returned from |

## Verification
Every register write, acknowledge and return takes effect at the first rising edge it is held across. Read data, `irq_req` and the vector outputs follow the new state combinationally in the same cycle. The bench therefore drives its inputs at the falling edge, steps one rising edge, and samples at the next falling edge. The one exception is a level line after an exception return. The active bit falls at the return edge, and the line only sets pending again at the edge after that, so that check waits one more cycle before it samples.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int NUM_IRQ    = 32;
    localparam int PRIO_W     = 8;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int VEC_OFS    = 16;
    localparam int LANES      = DATA_W / PRIO_W;
    localparam int PRIO_REGS  = NUM_IRQ / LANES;
    localparam int ID_W       = $clog2(NUM_IRQ);
    localparam int PIDX_W     = $clog2(PRIO_REGS);
    localparam int VEC_W      = $clog2(NUM_IRQ + VEC_OFS);

    localparam logic [ADDR_W-1:0] A_SET_EN   = 8'h00;
    localparam logic [ADDR_W-1:0] A_CLR_EN   = 8'h04;
    localparam logic [ADDR_W-1:0] A_SET_PEND = 8'h08;
    localparam logic [ADDR_W-1:0] A_CLR_PEND = 8'h0C;
    localparam logic [ADDR_W-1:0] A_PRIO_LO  = 8'h20;
    localparam logic [ADDR_W-1:0] A_PRIO_HI  = ADDR_W'(32 + 4 * PRIO_REGS);

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SET_EN,
        OP_CLR_EN,
        OP_SET_PEND,
        OP_CLR_PEND,
        OP_PRIO
    } reg_op_e;

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } cand_t;

    function automatic reg_op_e decode_op(input logic [ADDR_W-1:0] a);
        if (a == A_SET_EN)        return OP_SET_EN;
        else if (a == A_CLR_EN)   return OP_CLR_EN;
        else if (a == A_SET_PEND) return OP_SET_PEND;
        else if (a == A_CLR_PEND) return OP_CLR_PEND;
        else if (a >= A_PRIO_LO && a < A_PRIO_HI && a[1:0] == 2'b00) return OP_PRIO;
        else return OP_NONE;
    endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick
    import irq_ctrl_pkg::*;
(
    input  logic [NUM_IRQ-1:0]             cand,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
    output cand_t                          best
);

    // Linear scan: strict less-than keeps the lower index on ties.
    always_comb begin
        best = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand[i] && (!best.valid || prio[i] < best.prio)) begin
                best.valid = 1'b1;
                best.id    = ID_W'(i);
                best.prio  = prio[i];
            end
        end
    end

    // R6: the winner is always a member of the candidate set
    always_comb begin
        if (best.valid) a_r6_pick_in_set: assert (cand[best.id]);
    end

endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
    import irq_ctrl_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [PIDX_W-1:0]              idx,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rd_word,
    output logic [NUM_IRQ-1:0][PRIO_W-1:0] prio
);

    logic [PRIO_REGS-1:0][DATA_W-1:0] words;

    always_ff @(posedge clk) begin
        if (rst)        words <= '0;
        else if (wr_en) words[idx] <= wdata;
    end

    assign rd_word = words[idx];

    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_lane
        assign prio[n] = words[n / LANES][PRIO_W * (n % LANES) +: PRIO_W];
    end

    // R5: a written word is visible in the next cycle
    a_r5_word_written: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> words[$past(idx)] == $past(wdata));

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
    import irq_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] lines,
    input  reg_op_e            op,
    input  logic [NUM_IRQ-1:0] wmask,
    input  logic               ack_fire,
    input  logic [ID_W-1:0]    ack_id,
    input  logic               ret_fire,
    input  logic [ID_W-1:0]    ret_id,
    output logic [NUM_IRQ-1:0] en,
    output logic [NUM_IRQ-1:0] pend,
    output logic [NUM_IRQ-1:0] act
);

    logic [NUM_IRQ-1:0] en_n, pend_n, act_n;

    always_comb begin
        en_n   = en;
        pend_n = pend;
        act_n  = act;
        case (op)
            OP_SET_EN:   en_n   = en | wmask;
            OP_CLR_EN:   en_n   = en & ~wmask;
            OP_SET_PEND: pend_n = pend | wmask;
            OP_CLR_PEND: pend_n = pend & ~(wmask & ~act);
            default: ;
        endcase
        // level lines re-pend unless already in service
        pend_n = pend_n | (lines & ~act);
        if (ret_fire) act_n[ret_id] = 1'b0;
        if (ack_fire) begin
            act_n[ack_id]  = 1'b1;
            pend_n[ack_id] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= '0;
            pend <= '0;
            act  <= '0;
        end else begin
            en   <= en_n;
            pend <= pend_n;
            act  <= act_n;
        end
    end

    a_r8_ack_moves: assert property (@(posedge clk) disable iff (rst)
        ack_fire |=> act[$past(ack_id)] && !pend[$past(ack_id)]);

    a_r10_return_clears: assert property (@(posedge clk) disable iff (rst)
        (ret_fire && !(ack_fire && ack_id == ret_id)) |=> !act[$past(ret_id)]);

    a_r11_active_sticky: assert property (@(posedge clk) disable iff (rst)
        !ret_fire |=> (($past(act) & ~act) == '0));

    a_r2_clear_enable: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLR_EN) |=> ((en & $past(wmask)) == '0));

endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core
    import irq_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic               reg_we,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec_num,
    output logic [31:0]        irq_vec_addr,
    input  logic               irq_ack,
    input  logic               exc_ret,
    input  logic [ID_W-1:0]    exc_ret_id
);

    reg_op_e                    addr_op, wr_op;
    logic [PIDX_W-1:0]          prio_idx;
    logic [DATA_W-1:0]          prio_word;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
    logic [NUM_IRQ-1:0]         en, pend, act;
    cand_t                      best, top_act;
    logic                       ack_fire;

    assign addr_op  = decode_op(reg_addr);
    assign wr_op    = reg_we ? addr_op : OP_NONE;
    assign prio_idx = PIDX_W'((reg_addr - A_PRIO_LO) >> 2);

    irq_prio_bank u_prio (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_op == OP_PRIO),
        .idx     (prio_idx),
        .wdata   (reg_wdata),
        .rd_word (prio_word),
        .prio    (prio)
    );

    irq_state_bank u_state (
        .clk      (clk),
        .rst      (rst),
        .lines    (irq_lines),
        .op       (wr_op),
        .wmask    (reg_wdata[NUM_IRQ-1:0]),
        .ack_fire (ack_fire),
        .ack_id   (best.id),
        .ret_fire (exc_ret),
        .ret_id   (exc_ret_id),
        .en       (en),
        .pend     (pend),
        .act      (act)
    );

    irq_pick u_pick_cand (
        .cand (pend & en & ~act),
        .prio (prio),
        .best (best)
    );

    irq_pick u_pick_act (
        .cand (act),
        .prio (prio),
        .best (top_act)
    );

    assign irq_req      = best.valid && (!top_act.valid || best.prio < top_act.prio);
    assign ack_fire     = irq_ack && irq_req;
    assign irq_vec_num  = VEC_W'(best.id) + VEC_W'(VEC_OFS);
    assign irq_vec_addr = 32'({irq_vec_num, 2'b00});

    always_comb begin
        case (addr_op)
            OP_SET_EN, OP_CLR_EN:     reg_rdata = DATA_W'(en);
            OP_SET_PEND, OP_CLR_PEND: reg_rdata = DATA_W'(pend);
            OP_PRIO:                  reg_rdata = prio_word;
            default:                  reg_rdata = '0;
        endcase
    end

    // R4: a request always names a pending, enabled, idle line
    a_r4_req_enabled: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (en[best.id] && pend[best.id] && !act[best.id]));

    // R9: a request never stands while a no-less-urgent line is in service
    a_r9_no_equal_preempt: assert property (@(posedge clk) disable iff (rst)
        (irq_req && top_act.valid) |-> (prio[best.id] != prio[top_act.id]));

endmodule

// File: tb/irq_ctrl_core_tb.sv
module irq_ctrl_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_lines = '0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [5:0]  irq_vec_num;
    logic [31:0] irq_vec_addr;
    logic        irq_ack = 1'b0;
    logic        exc_ret = 1'b0;
    logic [4:0]  exc_ret_id = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_ctrl_core u_dut (
        .clk(clk), .rst(rst), .irq_lines(irq_lines),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec_num(irq_vec_num),
        .irq_vec_addr(irq_vec_addr), .irq_ack(irq_ack), .exc_ret(exc_ret),
        .exc_ret_id(exc_ret_id)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ck(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        step();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ack();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
    endtask

    task automatic ret(input logic [4:0] id);
        exc_ret = 1'b1; exc_ret_id = id; step(); exc_ret = 1'b0;
    endtask

    task automatic cleanup();
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        for (int k = 0; k < 8; k++) wr(8'h20 + 8'(4 * k), 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); ck("R1 enable after reset", d, 0);
        rd(8'h08, d); ck("R1 pending after reset", d, 0);
        rd(8'h3C, d); ck("R1 priority after reset", d, 0);
        ck("R1 request after reset", 32'(irq_req), 0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(8'h00, 32'h0000_00F0);
        rd(8'h00, d); ck("R2 set-enable readback", d, 32'hF0);
        rd(8'h04, d); ck("R2 clear-enable address readback", d, 32'hF0);
        wr(8'h00, 32'h0000_0003);
        rd(8'h00, d); ck("R2 zero bits keep enables", d, 32'hF3);
        wr(8'h04, 32'h0000_0011);
        rd(8'h04, d); ck("R2 clear-enable", d, 32'hE2);
        wr(8'h04, 32'h0);
        rd(8'h00, d); ck("R2 clear with zero no effect", d, 32'hE2);
        wr(8'h04, 32'hFFFF_FFFF);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        wr(8'h08, 32'h5);
        rd(8'h0C, d); ck("R3 set-pending readback", d, 32'h5);
        wr(8'h0C, 32'h4);
        rd(8'h08, d); ck("R3 clear-pending", d, 32'h1);
        wr(8'h0C, 32'h1);
        rd(8'h08, d); ck("R3 pending cleared", d, 32'h0);
    endtask

    task automatic t_disabled_line();
        logic [31:0] d;
        irq_lines[3] = 1'b1; step();
        irq_lines[3] = 1'b0;
        rd(8'h08, d); ck("R4 disabled line pends", d, 32'h8);
        ck("R4 no request while disabled", 32'(irq_req), 0);
        step();
        rd(8'h08, d); ck("R4 pending latched after line drop", d, 32'h8);
        wr(8'h00, 32'h8);
        ck("R4 request after enable", 32'(irq_req), 1);
        ck("R7 vector for line 3", 32'(irq_vec_num), 19);
        ck("R7 address for line 3", irq_vec_addr, 32'h4C);
        cleanup();
        ck("R3 request gone after clear", 32'(irq_req), 0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        wr(8'h00, (32'h1 << 5) | (32'h1 << 26) | (32'h1 << 27));
        wr(8'h38, 32'h1122_3344);
        rd(8'h38, d); ck("R5 priority word readback", d, 32'h1122_3344);
        wr(8'h08, (32'h1 << 5) | (32'h1 << 26));
        ck("R6 value zero wins", 32'(irq_vec_num), 21);
        wr(8'h24, 32'h0000_3000);
        ck("R5 lane 1 of word 1 moves line 5", 32'(irq_vec_num), 42);
        ck("R7 line 26 address", irq_vec_addr, 32'hA8);
        wr(8'h08, 32'h1 << 27);
        ck("R6 lower value wins over lower index", 32'(irq_vec_num), 43);
        ck("R7 line 27 address", irq_vec_addr, 32'hAC);
        wr(8'h38, 32'h2222_2222);
        ck("R6 tie goes to lower line", 32'(irq_vec_num), 42);
        cleanup();
    endtask

    task automatic t_service();
        logic [31:0] d;
        wr(8'h20, 32'h0010_0000);   // line 2 -> 0x10
        wr(8'h24, 32'h0000_0040);   // line 4 -> 0x40
        wr(8'h28, 32'h0040_0000);   // line 10 -> 0x40
        wr(8'h00, 32'h414);
        wr(8'h08, 32'h400);
        ck("R9 request with nothing active", 32'(irq_req), 1);
        ck("R7 vector line 10", 32'(irq_vec_num), 26);
        ack();
        rd(8'h08, d); ck("R8 ack clears pending", d, 32'h0);
        ck("R8 active line not requested", 32'(irq_req), 0);
        wr(8'h08, 32'h10);
        ck("R9 equal value cannot preempt", 32'(irq_req), 0);
        wr(8'h08, 32'h4);
        ck("R9 more urgent preempts", 32'(irq_req), 1);
        ck("R9 preempting vector", 32'(irq_vec_num), 18);
        wr(8'h0C, 32'h4);
        ck("R3 withdrawn preemption", 32'(irq_req), 0);
        wr(8'h08, 32'h400);
        rd(8'h08, d); ck("R11 pending separate from active", d, 32'h410);
        wr(8'h0C, 32'h400);
        rd(8'h08, d); ck("R11 clear-pending ignored on active", d, 32'h410);
        wr(8'h04, 32'h400);
        rd(8'h00, d); ck("R2 line 10 disabled", d, 32'h14);
        ck("R11 disabled line stays active", 32'(irq_req), 0);
        ret(5'd10);
        ck("R10 return releases blocked line", 32'(irq_req), 1);
        ck("R10 vector after return", 32'(irq_vec_num), 20);
        ack();
        ck("R8 line 4 taken", 32'(irq_req), 0);
        ret(5'd4);
        ck("R10 nothing left enabled", 32'(irq_req), 0);
        cleanup();
        rd(8'h08, d); ck("R3 cleanup of idle pending", d, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        irq_lines[7] = 1'b1;
        wr(8'h0C, 32'h80);
        rd(8'h08, d); ck("R12 level beats clear-pending", d, 32'h80);
        wr(8'h00, 32'h80);
        ck("R7 vector line 7", 32'(irq_vec_num), 23);
        ack();
        rd(8'h08, d); ck("R12 no re-pend while active", d, 32'h0);
        step();
        rd(8'h08, d); ck("R12 still no re-pend", d, 32'h0);
        ret(5'd7);
        step();
        rd(8'h08, d); ck("R12 re-pends after return", d, 32'h80);
        ck("R12 request again", 32'(irq_req), 1);
        irq_lines[7] = 1'b0;
        cleanup();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_enable();
        t_pending();
        t_disabled_line();
        t_priority();
        t_service();
        t_level();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule